// File: doc/BRIEF.md
# VFD Grid Multiplex Scanner with Dimming

This block produces the time-multiplexed drive for a vacuum fluorescent display. A frame is a run of digit periods, one per enabled grid, followed by one extra period set aside for key scanning. Every period is split into 16 sub-ticks, each advanced by a prescaled oscillator tick. In a digit period the grid for that digit is driven for the first W sub-ticks, where W comes from an 8-step, non-linear dimming table. The digit's segment word is shown in the same window and blanked outside it.

The 3-bit display-mode code trades digit count against segment count, because five physical pins serve as either a high segment or a high grid. The segment word for each digit comes from a byte-wide display memory through a combinational read port. The block places a digit index on `rd_idx_o`. The memory returns both bytes of that digit on `rd_data_i` in the same cycle. The block captures the word at the digit boundary. This read port has no valid/ready handshake because the memory always answers at once, so there is no back-pressure. Mode, dim code and the on/off bit are sampled only at digit boundaries.

Top module: `vfd_scan`

## Requirements
- R1: After reset the latched mode is 111 (11 digits, 11 segments), the dim code is 000, the display is off, and the outputs are low: `grid_o`=0, `seg_o`=0, `key_slot_o`=0, `frame_end_o`=0. The first period is digit 0.
- R2: Each period lasts 16 ticks. Digit periods run in order 0,1,...,n-1, then the key-scan period, then digit 0 again. `grid_o` bit k belongs to digit k.
- R3: Mode code m gives n = m+4 digits. It gives 16 segments for m ≤ 2 and 18−m segments otherwise. Segment bits at or above the segment count stay 0.
- R4: In digit k, `seg_o` bit i shows bit i of the word {byte 2k+1, byte 2k}. Byte 2k supplies bits 7:0, with its bits 3:0 as the low nibble and bits 7:4 as the high nibble. Byte 2k+1 supplies bits 15:8. The block requests digit k with `rd_idx_o`=k and captures `rd_data_i` = {byte 2k+1, byte 2k} at the boundary into digit k.
- R5: Dim codes 000..111 give an active width of 1, 2, 4, 10, 11, 12, 13 and 14 sub-ticks. The grid and segments are active only in sub-ticks 0..W−1 of a digit period.
- R6: With the display off, `grid_o` and `seg_o` are 0. Period and frame timing, `key_slot_o` and `frame_end_o` still run.
- R7: `key_slot_o` is high for the whole key-scan period and only then. In that period `grid_o` and `seg_o` are 0.
- R8: `frame_end_o` pulses high for exactly one clock, in the cycle after the tick that ends the key-scan period.
- R9: Changes on `mode_i`, `dim_i` and `disp_on_i` take effect only at the next period boundary. The digit that follows that boundary is chosen using the new mode.
- R10: For j = 0..4, `seg_o[11+j]` and `grid_o[10-j]` are never high together.
- R11: `grid_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle sub-tick pulse from the prescaled oscillator |
| mode_i | input | 3 | Display-mode code (digit/segment split) |
| dim_i | input | 3 | Dimming code |
| disp_on_i | input | 1 | Display enable |
| rd_idx_o | output | 4 | Digit index presented to display memory |
| rd_data_i | input | 16 | Two memory bytes of that digit, {odd byte, even byte} |
| grid_o | output | 11 | One-hot grid drive |
| seg_o | output | 16 | Segment drive |
| key_slot_o | output | 1 | High during the key-scan period |
| frame_end_o | output | 1 | One-clock end-of-frame strobe |

## Verification
The assertions check several properties on every cycle:
- The grid vector is one-hot or zero.
- A shared pin is never claimed as both a segment and a grid.
- Outputs are blank in the key slot and while the display is off.
- The frame-end strobe lasts only one cycle.
- Latched configuration changes only at a boundary.
- The sub-tick counter wraps at the boundary and the digit index stays inside the latched digit count.

Only the bench scenarios show the rest, because each needs an independent reference:
- the exact width of each dimming step;
- the byte-to-segment mapping from memory;
- the digit count that each mode produces;
- the deferred effect of a mid-period configuration change.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  localparam int MODE_W  = 3;
  localparam int DIM_W   = 3;
  localparam int MAX_DIG = 11;
  localparam int SEG_MAX = 16;
  localparam int SUB_W   = 4;
  localparam int DIG_W   = $clog2(MAX_DIG);
  localparam int CNT_W   = 5;

  // digit count for a mode code: 4..11
  function automatic logic [CNT_W-1:0] digits_of(input logic [MODE_W-1:0] m);
    return CNT_W'(m) + CNT_W'(4);
  endfunction

  // segment count for a mode code: 16 for low modes, then one fewer per digit
  function automatic logic [CNT_W-1:0] segs_of(input logic [MODE_W-1:0] m);
    if (m < MODE_W'(3)) return CNT_W'(16);
    return CNT_W'(18) - CNT_W'(m);
  endfunction

  // active sub-ticks for a dim code (non-linear table)
  function automatic logic [CNT_W-1:0] width_of(input logic [DIM_W-1:0] d);
    case (d)
      3'd0:    return CNT_W'(1);
      3'd1:    return CNT_W'(2);
      3'd2:    return CNT_W'(4);
      default: return CNT_W'(d) + CNT_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/vfd_subtick_timer.sv
module vfd_subtick_timer #(
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             bnd_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;

  logic [SUB_W-1:0] sub_q;

  assign bnd_o = tick_i && (sub_q == SUB_LAST);
  assign sub_o = sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sub_q <= '0;
    else if (tick_i) sub_q <= sub_q + SUB_W'(1);
  end

  // R2: a boundary tick returns the sub-tick count to zero
  p_sub_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_o |=> (sub_q == '0));

  // R2: without a tick the sub-tick count holds
  p_sub_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(sub_q));

endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DIM_W-1:0]  dim_i,
  input  logic              on_i,
  input  logic [SEG_W-1:0]  rd_data_i,
  output logic [DIG_W-1:0]  rd_idx_o,
  output logic [DIG_W-1:0]  dig_o,
  output logic              key_o,
  output logic              eof_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DIM_W-1:0]  dim_o,
  output logic              on_o,
  output logic [SEG_W-1:0]  word_o
);
  localparam logic [MODE_W-1:0] MODE_RST = '1;

  logic [DIG_W-1:0]  dig_q, nxt_dig;
  logic              key_q, nxt_key, eof_q, on_q;
  logic [MODE_W-1:0] mode_q;
  logic [DIM_W-1:0]  dim_q;
  logic [SEG_W-1:0]  word_q;
  logic [CNT_W-1:0]  n_new, d_inc;

  assign n_new = digits_of(mode_i);
  assign d_inc = CNT_W'(dig_q) + CNT_W'(1);

  // next period, using the mode that will be latched at this boundary
  always_comb begin
    nxt_dig = dig_q;
    nxt_key = 1'b0;
    if (key_q)                nxt_dig = '0;
    else if (d_inc >= n_new)  nxt_key = 1'b1;
    else                      nxt_dig = d_inc[DIG_W-1:0];
  end

  assign rd_idx_o = nxt_dig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q  <= '0;
      key_q  <= 1'b0;
      eof_q  <= 1'b0;
      mode_q <= MODE_RST;
      dim_q  <= '0;
      on_q   <= 1'b0;
      word_q <= '0;
    end else begin
      eof_q <= bnd_i && key_q;
      if (bnd_i) begin
        dig_q  <= nxt_dig;
        key_q  <= nxt_key;
        mode_q <= mode_i;
        dim_q  <= dim_i;
        on_q   <= on_i;
        if (!nxt_key) word_q <= rd_data_i;
      end
    end
  end

  assign dig_o  = dig_q;
  assign key_o  = key_q;
  assign eof_o  = eof_q;
  assign mode_o = mode_q;
  assign dim_o  = dim_q;
  assign on_o   = on_q;
  assign word_o = word_q;

  // R8: the frame-end strobe never lasts two cycles
  p_eof_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |=> !eof_q);

  // R9: latched configuration moves only at a boundary
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_i |=> ($stable(mode_q) && $stable(dim_q) && $stable(on_q)));

  // R3: a digit period always lies inside the latched digit count
  p_dig_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_q |-> (CNT_W'(dig_q) < digits_of(mode_q)));

  // R7: the key period is always followed by digit 0
  p_key_then_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q && bnd_i) |=> (!key_q && dig_q == '0));

endmodule

// File: rtl/vfd_drive_out.sv
module vfd_drive_out
  import vfd_scan_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int GRID_N = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DIG_W-1:0]  dig_i,
  input  logic              key_i,
  input  logic              on_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DIM_W-1:0]  dim_i,
  input  logic [SEG_W-1:0]  word_i,
  output logic [GRID_N-1:0] grid_o,
  output logic [SEG_W-1:0]  seg_o
);
  localparam int SHARED = 5;

  logic             win;
  logic [SEG_W-1:0] mask;
  logic [CNT_W-1:0] segs;

  assign win  = on_i && !key_i && (CNT_W'(sub_i) < width_of(dim_i));
  assign segs = segs_of(mode_i);

  for (genvar g = 0; g < GRID_N; g++) begin : g_grid
    assign grid_o[g] = win && (dig_i == DIG_W'(g));
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_mask
    assign mask[s] = (CNT_W'(s) < segs);
  end

  assign seg_o = win ? (word_i & mask) : '0;

  // R11: at most one grid
  p_grid_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o));

  // R10: a shared pin is either a segment or a grid, never both
  for (genvar j = 0; j < SHARED; j++) begin : g_shared
    p_shared_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_o[SEG_W-SHARED+j] && grid_o[GRID_N-1-j]));
  end

  // R7: key period is blank
  p_blank_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_i |-> (grid_o == '0 && seg_o == '0));

  // R6: display off is blank
  p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !on_i |-> (grid_o == '0 && seg_o == '0));

endmodule

// File: rtl/vfd_scan.sv
module vfd_scan
  import vfd_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [2:0]   mode_i,
  input  logic [2:0]   dim_i,
  input  logic         disp_on_i,
  output logic [3:0]   rd_idx_o,
  input  logic [15:0]  rd_data_i,
  output logic [10:0]  grid_o,
  output logic [15:0]  seg_o,
  output logic         key_slot_o,
  output logic         frame_end_o
);
  logic [SUB_W-1:0]   sub;
  logic               bnd;
  logic [DIG_W-1:0]   dig;
  logic               key, on_l;
  logic [MODE_W-1:0]  mode_l;
  logic [DIM_W-1:0]   dim_l;
  logic [SEG_MAX-1:0] word;

  vfd_subtick_timer #(.SUB_W(SUB_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sub_o(sub), .bnd_o(bnd)
  );

  vfd_slot_seq #(.SEG_W(SEG_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .bnd_i(bnd),
    .mode_i(mode_i), .dim_i(dim_i), .on_i(disp_on_i),
    .rd_data_i(rd_data_i), .rd_idx_o(rd_idx_o),
    .dig_o(dig), .key_o(key), .eof_o(frame_end_o),
    .mode_o(mode_l), .dim_o(dim_l), .on_o(on_l), .word_o(word)
  );

  vfd_drive_out #(.SEG_W(SEG_MAX), .GRID_N(MAX_DIG)) u_drive (
    .clk(clk), .rst_n(rst_n), .sub_i(sub), .dig_i(dig), .key_i(key),
    .on_i(on_l), .mode_i(mode_l), .dim_i(dim_l), .word_i(word),
    .grid_o(grid_o), .seg_o(seg_o)
  );

  assign key_slot_o = key;

endmodule

// File: tb/vfd_scan_bench.sv
module vfd_scan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic [2:0]  dim = 3'd0;
  logic        on = 1'b0;
  logic [3:0]  rd_idx;
  logic [15:0] rd_data;
  logic [10:0] grid;
  logic [15:0] seg;
  logic        key_slot, frame_end;
  logic [7:0]  mem [22];

  int n_chk = 0;
  int n_err = 0;

  // model state
  int   m_dig, m_sub, m_mode, m_dim;
  bit   m_key, m_on, m_eof;
  logic [15:0] m_word;

  always #2 clk = ~clk;

  assign rd_data = (rd_idx < 4'd11) ? {mem[2*rd_idx+1], mem[2*rd_idx]} : 16'h0;

  vfd_scan u_vfd_scan (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .dim_i(dim),
    .disp_on_i(on), .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .grid_o(grid), .seg_o(seg), .key_slot_o(key_slot), .frame_end_o(frame_end)
  );

  function automatic int f_digits(int m); return m + 4; endfunction
  function automatic int f_segs(int m); return (m < 3) ? 16 : 18 - m; endfunction
  function automatic int f_width(int d);
    int t[8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return t[d];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dig = 0; m_sub = 0; m_mode = 7; m_dim = 0;
    m_key = 0; m_on = 0; m_eof = 0; m_word = '0;
  endtask

  task automatic model_step();
    m_eof = 0;
    if (tick) begin
      if (m_sub == 15) begin
        int nd = f_digits(int'(mode));
        int ndig = m_dig;
        bit nkey = 0;
        if (m_key) begin ndig = 0; m_eof = 1; end
        else if (m_dig + 1 >= nd) nkey = 1;
        else ndig = m_dig + 1;
        if (!nkey) m_word = {mem[2*ndig+1], mem[2*ndig]};
        m_dig = ndig; m_key = nkey;
        m_mode = int'(mode); m_dim = int'(dim); m_on = on;
        m_sub = 0;
      end else m_sub++;
    end
  endtask

  task automatic compare();
    bit win = m_on && !m_key && (m_sub < f_width(m_dim));
    logic [15:0] mask = 16'((32'd1 << f_segs(m_mode)) - 1);
    logic [10:0] g_exp = win ? 11'(11'd1 << m_dig) : 11'd0;
    logic [15:0] s_exp = win ? (m_word & mask) : 16'd0;
    chk(grid == g_exp, "R2 grid", 32'(grid), 32'(g_exp));
    chk(seg == s_exp, "R4 segments", 32'(seg), 32'(s_exp));
    chk(key_slot == m_key, "R7 key slot", 32'(key_slot), 32'(m_key));
    chk(frame_end == m_eof, "R8 frame end", 32'(frame_end), 32'(m_eof));
    chk((seg & ~mask) == 16'd0, "R3 segment count", 32'(seg), 32'(seg & mask));
    if (m_on && !m_key)
      chk((grid != 0) == win, "R5 dim window", 32'(grid != 0), 32'(win));
    if (!m_on)
      chk(grid == 0 && seg == 0, "R6 display off", 32'({grid, seg}), 32'd0);
    if (int'(mode) != m_mode || int'(dim) != m_dim || on != m_on)
      chk(grid == g_exp && seg == s_exp, "R9 deferred config", 32'({grid, seg}), 32'({g_exp, s_exp}));
    chk((seg[15:11] & {grid[6], grid[7], grid[8], grid[9], grid[10]}) == 0,
        "R10 shared pins", 32'(seg[15:11]), 32'd0);
    chk($countones(grid) <= 1, "R11 one-hot grid", 32'(grid), 32'd0);
  endtask

  task automatic cyc();
    @(negedge clk);
    if (!rst_n) model_reset(); else model_step();
    compare();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < 22; i++) mem[i] = 8'($urandom);
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(grid == 0 && seg == 0 && !key_slot && !frame_end, "R1 reset outputs",
        32'({grid, seg, key_slot, frame_end}), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: default 11x11 and off; frame timing still runs (R6)
    tick = 1'b1;
    repeat (12 * 16 + 4) cyc();
    // directed: each mode with matching dim code
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m); dim = 3'(m); on = 1'b1;
      for (int c = 0; c < (m + 5) * 16 * 2 + 40; c++) begin
        cyc();
        if (c % 37 == 0) mem[$urandom % 22] = 8'($urandom);
      end
    end
    // corner: all segments set, widest mode, to expose masking (R3)
    for (int i = 0; i < 22; i++) mem[i] = 8'hFF;
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m); dim = 3'd7;
      repeat ((m + 5) * 16 + 20) cyc();
    end
    // random phase
    for (int c = 0; c < 20000; c++) begin
      cyc();
      tick = ($urandom % 3) != 0;
      if ($urandom % 300 == 0) mode = 3'($urandom);
      if ($urandom % 200 == 0) dim = 3'($urandom);
      if ($urandom % 400 == 0) on = ~on;
      if ($urandom % 4 == 0) mem[$urandom % 22] = 8'($urandom);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule